// File: doc/BRIEF.md
# Binary-Search Loop Controller for a Digital PLL

This block is the digital loop filter of an all-digital phase-locked loop. It runs on the divided reference clock. In every cycle it reads one early/late decision from an external phase/frequency detector and moves a 17-bit oscillator control word. A larger word makes the oscillator slower. Each decision moves the word by the current step size, and the controller adapts that step size as it goes.

After a start, the controller runs a binary search to acquire the frequency. The word starts at mid-range and the step at a quarter of the range. The step halves each time the decision polarity flips. Once the step has fallen to 1, the controller switches to phase tracking.

In phase tracking, reversals still halve the step. A run of eight decisions in the same direction doubles the step, which lets the loop follow a drifting phase. The oscillator, detector and dividers are outside this block.

Top module: `bsearch_loop_ctrl`

## Requirements
- R1: After reset, and in every cycle that `enable_i` is low, the controller is in its start state: `code_o` = 65536 (mid-range), step = 32768, `track_o` = 0, `acq_done_o` = 0, with no previous decision remembered.
- R2: A decision is a cycle with `enable_i` high and exactly one of `lead_i`/`lag_i` high. `lead_i` adds the current step to `code_o` and `lag_i` subtracts it. The new value is visible after the next rising edge.
- R3: Code updates saturate at 0 and at 131071. They never wrap.
- R4: While acquiring (`track_o` = 0), a decision whose direction differs from the previous remembered decision halves the step used from the next decision on. The first decision after start is never a reversal.
- R5: When a reversal during acquisition brings the step to 1, `track_o` rises at that edge and stays high while enabled. At the same edge `acq_done_o` rises for exactly one cycle. The speed-up count starts at 0.
- R6: While tracking, a reversal halves the step (floor 1) and clears the speed-up count.
- R7: While tracking, each same-direction decision counts up. The eighth in a row doubles the step (cap 32768) and clears the count.
- R8: A cycle with neither or both of `lead_i`/`lag_i` high leaves the code, the step, the count and the remembered direction unchanged.
- R9: The step always stays between 1 and 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Loop run; low holds the start state |
| lead_i | input | 1 | Oscillator too fast; raise the code |
| lag_i | input | 1 | Oscillator too slow; lower the code |
| code_o | output | 17 | Oscillator control word |
| track_o | output | 1 | 0 = acquiring, 1 = tracking |
| acq_done_o | output | 1 | One-cycle pulse when acquisition ends |

## Verification
The bench drives the block against behavioural oscillators aimed at low, high and mid-range target codes. These runs show whether halving happens only on true reversals and whether the mode switches at exactly step 1. Targets at the two extremes produce no reversal at all, which isolates saturation at both ends. Long same-direction runs in tracking separate the eighth decision from the seventh and ninth, and they reach the step cap. Alternating decisions drive the step down to its floor. Idle, both-high and disabled cycles are interleaved to show that they leave the direction memory and the count untouched.

// File: rtl/bsearch_loop_pkg.sv
package bsearch_loop_pkg;
  typedef enum logic {
    MODE_ACQ   = 1'b0,
    MODE_TRACK = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/bsl_step_ctrl.sv
module bsl_step_ctrl
  import bsearch_loop_pkg::*;
#(
  parameter int W         = 17,
  parameter int BOOST_RUN = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         dec_i,
  input  logic         dir_i,   // 1 = lead
  output logic [W-1:0] step_o,
  output logic         track_o,
  output logic         done_o
);
  localparam int RW = $clog2(BOOST_RUN + 1);
  localparam logic [W-1:0] ONE_V     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] QUARTER_V = ONE_V << (W - 2);

  logic [W-1:0] step_q, step_d, half_s, dbl_s;
  logic [RW-1:0] run_q, run_d;
  loop_mode_e   mode_q, mode_d;
  logic         prev_q, prev_d, have_q, have_d, done_q, done_d, rev_s;

  assign half_s = (step_q > ONE_V) ? (step_q >> 1) : ONE_V;
  assign dbl_s  = (step_q >= (QUARTER_V >> 1)) ? QUARTER_V : (step_q << 1);
  assign rev_s  = have_q && (dir_i != prev_q);

  always_comb begin
    step_d = step_q;
    run_d  = run_q;
    mode_d = mode_q;
    prev_d = prev_q;
    have_d = have_q;
    done_d = 1'b0;
    if (init_i) begin
      step_d = QUARTER_V;
      run_d  = '0;
      mode_d = MODE_ACQ;
      prev_d = 1'b0;
      have_d = 1'b0;
    end else if (dec_i) begin
      prev_d = dir_i;
      have_d = 1'b1;
      if (mode_q == MODE_ACQ) begin
        if (rev_s) begin
          step_d = half_s;
          if (half_s == ONE_V) begin
            mode_d = MODE_TRACK;
            run_d  = '0;
            done_d = 1'b1;
          end
        end
      end else if (rev_s) begin
        step_d = half_s;
        run_d  = '0;
      end else if (run_q == RW'(BOOST_RUN - 1)) begin
        step_d = dbl_s;
        run_d  = '0;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= QUARTER_V;
      run_q  <= '0;
      mode_q <= MODE_ACQ;
      prev_q <= 1'b0;
      have_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      run_q  <= run_d;
      mode_q <= mode_d;
      prev_q <= prev_d;
      have_q <= have_d;
      done_q <= done_d;
    end
  end

  assign step_o  = step_q;
  assign track_o = (mode_q == MODE_TRACK);
  assign done_o  = done_q;

  p_step_bounds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q >= ONE_V) && (step_q <= QUARTER_V));
  p_run_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RW'(BOOST_RUN));
  p_track_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TRACK) && !init_i |=> mode_q == MODE_TRACK);
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_idle_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_i && !init_i |=> $stable(step_q) && $stable(run_q) && $stable(prev_q));
  p_init_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> step_q == QUARTER_V && mode_q == MODE_ACQ && !done_q);
endmodule

// File: rtl/bsl_code_acc.sv
module bsl_code_acc #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         dec_i,
  input  logic         dir_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] code_o
);
  localparam logic [W-1:0] MID_V = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q, code_d;
  logic [W:0]   sum_s;

  assign sum_s = {1'b0, code_q} + {1'b0, step_i};

  always_comb begin
    code_d = code_q;
    if (init_i)
      code_d = MID_V;
    else if (dec_i && dir_i)
      code_d = sum_s[W] ? {W{1'b1}} : sum_s[W-1:0];
    else if (dec_i)
      code_d = (code_q < step_i) ? '0 : (code_q - step_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= MID_V;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  p_idle_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_i && !init_i |=> $stable(code_q));
  p_lead_no_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && dir_i && !init_i |=> code_q >= $past(code_q));
  p_lag_no_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !dir_i && !init_i |=> code_q <= $past(code_q));
  p_init_mid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> code_q == MID_V);
endmodule

// File: rtl/bsearch_loop_ctrl.sv
module bsearch_loop_ctrl #(
  parameter int W         = 17,
  parameter int BOOST_RUN = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         lead_i,
  input  logic         lag_i,
  output logic [W-1:0] code_o,
  output logic         track_o,
  output logic         acq_done_o
);
  logic         init_s, dec_s;
  logic [W-1:0] step_s;

  assign init_s = !enable_i;
  assign dec_s  = enable_i && (lead_i ^ lag_i);  // both high counts as no decision

  bsl_step_ctrl #(.W(W), .BOOST_RUN(BOOST_RUN)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_s),
    .dec_i  (dec_s),
    .dir_i  (lead_i),
    .step_o (step_s),
    .track_o(track_o),
    .done_o (acq_done_o)
  );

  bsl_code_acc #(.W(W)) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_s),
    .dec_i  (dec_s),
    .dir_i  (lead_i),
    .step_i (step_s),
    .code_o (code_o)
  );

  p_done_with_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_done_o |-> track_o);
endmodule

// File: tb/tb_bsearch_loop_ctrl.sv
module tb_bsearch_loop_ctrl;
  localparam int MAXC = 131071;
  localparam int MIDC = 65536;
  localparam int QRT  = 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, ld = 1'b0, lg = 1'b0;
  logic [16:0] code;
  logic        trk, done;

  int total = 0, bad = 0, cyc_n = 0;
  bit finished = 0;

  int m_code, m_step, m_run;
  bit m_trk, m_done, m_prev, m_have;

  always #4 clk = ~clk;

  bsearch_loop_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .lead_i(ld), .lag_i(lg),
    .code_o(code), .track_o(trk), .acq_done_o(done)
  );

  task automatic m_init();
    m_code = MIDC; m_step = QRT; m_run = 0;
    m_trk = 0; m_done = 0; m_prev = 0; m_have = 0;
  endtask

  task automatic m_update(bit e, bit a, bit b);
    bit rev;
    if (!e) begin m_init(); return; end
    m_done = 0;
    if (a == b) return;
    rev = m_have && (a != m_prev);
    if (a) m_code = (m_code + m_step > MAXC) ? MAXC : m_code + m_step;
    else   m_code = (m_code < m_step) ? 0 : m_code - m_step;
    if (!m_trk) begin
      if (rev) begin
        m_step = (m_step > 1) ? m_step / 2 : 1;
        if (m_step == 1) begin m_trk = 1; m_run = 0; m_done = 1; end
      end
    end else if (rev) begin
      m_step = (m_step > 1) ? m_step / 2 : 1;
      m_run = 0;
    end else begin
      m_run++;
      if (m_run == 8) begin
        m_step = (m_step * 2 > QRT) ? QRT : m_step * 2;
        m_run = 0;
      end
    end
    m_prev = a; m_have = 1;
  endtask

  task automatic check(string tag);
    total++;
    if (code !== 17'(m_code) || trk !== m_trk || done !== m_done) begin
      bad++;
      $display("FAIL %s: code=%0d trk=%0b done=%0b expected code=%0d trk=%0b done=%0b",
               tag, code, trk, done, m_code, m_trk, m_done);
    end
  endtask

  task automatic expect_code(int exp, string tag);
    total++;
    if (code !== 17'(exp)) begin
      bad++;
      $display("FAIL %s: code=%0d expected %0d", tag, code, exp);
    end
  endtask

  // called at a negedge; drives, clocks, then compares at the next negedge
  task automatic cyc(bit e, bit a, bit b, string tag);
    en = e; ld = a; lg = b;
    @(posedge clk);
    @(negedge clk);
    m_update(e, a, b);
    check(tag);
  endtask

  // behavioural oscillator: code below target means too fast -> lead
  task automatic chase(int target, int n, string tag);
    for (int i = 0; i < n; i++) begin
      if (m_code < target) cyc(1, 1, 0, tag);
      else                 cyc(1, 0, 1, tag);
    end
  endtask

  initial begin
    m_init();
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    cyc(0, 1, 0, "R1 disabled");
    cyc(0, 0, 1, "R1 disabled");
    // saturation high: only leads, no reversal
    cyc(1, 1, 0, "R2 lead");
    expect_code(98304, "R2 lead adds step");
    cyc(1, 1, 0, "R3 sat high");
    expect_code(MAXC, "R3 sat high");
    cyc(1, 1, 0, "R3 sat high hold");
    cyc(1, 0, 1, "R4 first reversal");
    expect_code(MAXC - QRT, "R2 lag subtracts");
    cyc(0, 0, 0, "R1 restart");
    // saturation low
    cyc(1, 0, 1, "R3 lag");
    cyc(1, 0, 1, "R3 sat low");
    expect_code(0, "R3 sat low");
    cyc(1, 0, 1, "R3 sat low hold");
    // idle and both-high keep direction memory
    cyc(1, 0, 0, "R8 idle");
    cyc(1, 1, 1, "R8 both");
    cyc(1, 0, 1, "R8 no false reversal");
    cyc(0, 0, 0, "R1 restart");
    // acquisitions toward several targets
    chase(1000, 40, "R4 acq low target");
    chase(1000, 30, "R6 track low target");
    cyc(0, 0, 0, "R1 restart");
    chase(100003, 40, "R5 acq high target");
    cyc(0, 0, 0, "R1 restart");
    chase(MIDC + 7, 40, "R5 acq mid target");
    // long same-direction runs: doubling and cap
    for (int i = 0; i < 130; i++) cyc(1, 1, 0, "R7 lead run");
    for (int i = 0; i < 20; i++) cyc(1, (i % 2) == 0, (i % 2) != 0, "R6 alternate");
    for (int i = 0; i < 7; i++) cyc(1, 0, 1, "R7 lag run");
    cyc(1, 0, 0, "R8 idle in track");
    cyc(1, 1, 1, "R8 both in track");
    for (int i = 0; i < 12; i++) cyc(1, 0, 1, "R7 lag run cont");
    for (int i = 0; i < 140; i++) cyc(1, 0, 1, "R9 lag to floor code");
    cyc(0, 1, 0, "R1 disable from track");
    chase(2222, 60, "R4 reacquire");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cyc_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule